// File: doc/BRIEF.md
# Flash Block Reclamation Sequencer

This block drives one reclamation pass over a small array of flash blocks whose bookkeeping lives in on-chip tables: a valid-page bitmap per block, the logical address recorded for every physical page, and a wear counter per block. The sequencer waits in idle until the free-block count supplied by the surrounding logic falls under a programmable limit, or until the host side reports that it is quiet. It then asks an external selector for a victim block and an erased destination block.

Every page still valid in the victim is copied through a request/acknowledge handshake into the next unused page of the destination. Each copy is followed by a one-cycle write to the logical-to-physical map. When the victim holds no more live data, the sequencer issues a whole-block erase through a second handshake. After the erase it clears the victim's bitmap, bumps its wear counter and pushes the block index back to the free pool.

A foreground input stalls host writes until a block has been reclaimed. Separate counters of host page writes and reclamation copies give the write amplification as a ratio. Page payloads and flash timing are not modelled here; the two acknowledges stand in for them.

Top module: `gc_seq`

## Requirements
- R1: While idle, a pass begins (victimReq high one cycle after the sampling edge) when freeCount < threshold or hostIdle is high. With freeCount >= threshold and hostIdle low, victimReq stays low.
- R2: The victim and destination indices are captured from victimIdx and dstIdx on the edge where victimVld is high while victimReq is high.
- R3: Valid victim pages are copied in ascending page order to destination pages 0, 1, 2, ... in turn. copyReq and its addresses hold steady until copyAck.
- R4: In the cycle after each accepted copy, mapWe pulses once with mapLpa equal to the logical address recorded for the source page and mapPpa = dstBlk * PAGES + dstPage, with the block index in the upper bits.
- R5: eraseReq for the victim is raised only after every valid page has been copied, and it is held until eraseAck.
- R6: After the erase is acknowledged, the victim's valid bitmap reads zero, its wear counter has risen by one, and the destination shows one valid page per copy.
- R7: In the cycle after eraseAck, freePush pulses for exactly one cycle with freeBlk equal to the victim, and the sequencer returns to idle.
- R8: A victim with no valid pages skips copying and map updates: eraseReq is high in the cycle right after the victim is accepted.
- R9: hostStall rises in the cycle after fgMode is sampled high. It falls in the cycle after freePush, unless fgMode is high at that edge.
- R10: hostWrCnt counts host page writes and gcWrCnt counts accepted copies, each by one.
- R11: A host write sets the addressed page's valid bit and records hostWrLpa as its logical address. A host invalidate clears the bit. probeValid bit p shows page p of probeBlk.
- R12: At most one of victimReq, copyReq, mapWe, eraseReq and freePush is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freeCount | input | FREE_W | Current number of free blocks |
| threshold | input | FREE_W | Low-space trigger limit |
| hostIdle | input | 1 | Host interface quiet, start a pass |
| fgMode | input | 1 | Free count at hard minimum |
| hostStall | output | 1 | Hold off host writes |
| victimReq | output | 1 | Request for a victim choice |
| victimVld | input | 1 | Victim and destination indices valid |
| victimIdx | input | BLK_W | Victim block |
| dstIdx | input | BLK_W | Erased destination block |
| copyReq | output | 1 | Page copy request |
| copyAck | input | 1 | Page copy done |
| copySrcBlk | output | BLK_W | Copy source block |
| copySrcPage | output | PG_W | Copy source page |
| copyDstBlk | output | BLK_W | Copy destination block |
| copyDstPage | output | PG_W | Copy destination page |
| mapWe | output | 1 | Map entry write strobe |
| mapLpa | output | LPA_W | Logical address to remap |
| mapPpa | output | PPA_W | New physical page address |
| eraseReq | output | 1 | Block erase request |
| eraseAck | input | 1 | Block erase done |
| eraseBlk | output | BLK_W | Block to erase |
| freePush | output | 1 | Return block to free pool |
| freeBlk | output | BLK_W | Block being returned |
| hostWrEn | input | 1 | Host page write |
| hostWrBlk | input | BLK_W | Host write block |
| hostWrPage | input | PG_W | Host write page |
| hostWrLpa | input | LPA_W | Host write logical address |
| hostInvEn | input | 1 | Host page invalidate |
| hostInvBlk | input | BLK_W | Invalidate block |
| hostInvPage | input | PG_W | Invalidate page |
| hostWrCnt | output | CNT_W | Host page writes so far |
| gcWrCnt | output | CNT_W | Reclamation copies so far |
| probeBlk | input | BLK_W | Block to inspect |
| probeValid | output | PAGES | Valid bitmap of probeBlk |
| probeErase | output | ERASE_W | Wear counter of probeBlk |

## Verification
The hardest situation to reach is a victim whose live pages are scattered, so that the scan has to skip holes before each copy and the destination pointer runs out of step with the source pointer. The stimulus writes every page of a block through the host port, then invalidates a chosen subset. It sweeps all sixteen bitmaps of a four-page block, including the empty one that has to go straight to erase, and varies the acknowledge latencies, the trigger source and the victim/destination pairing with each pattern.

// File: rtl/gc_seq_pkg.sv
package gc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SCAN,
    ST_COPY,
    ST_MAP,
    ST_ERASE,
    ST_RECLAIM
  } gcState_t;

  // Strobes from control to datapath, one per table or pointer update
  typedef struct packed {
    logic latch;      // capture victim / destination, rewind pointers
    logic skip;       // step source pointer over an invalid page
    logic copyDone;   // copy acknowledged: mark destination page
    logic advance;    // map written: step both pointers
    logic eraseDone;  // erase acknowledged: clear bitmap, count wear
  } gcStrobe_t;

endpackage

// File: rtl/gc_seq_ctrl.sv
module gc_seq_ctrl
  import gc_seq_pkg::*;
#(
  parameter int FREE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FREE_W-1:0] freeCount,
  input  logic [FREE_W-1:0] threshold,
  input  logic              hostIdle,
  input  logic              fgMode,
  input  logic              victimVld,
  input  logic              victimEmpty,
  input  logic              curValid,
  input  logic              pLast,
  input  logic              copyAck,
  input  logic              eraseAck,
  output gcStrobe_t         stb,
  output logic              victimReq,
  output logic              copyReq,
  output logic              mapWe,
  output logic              eraseReq,
  output logic              freePush,
  output logic              hostStall
);

  gcState_t state, nextState;
  logic stallQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if ((freeCount < threshold) || hostIdle) nextState = ST_SELECT;
      ST_SELECT:  if (victimVld) nextState = victimEmpty ? ST_ERASE : ST_SCAN;
      ST_SCAN:    if (curValid) nextState = ST_COPY;
                  else if (pLast) nextState = ST_ERASE;
      ST_COPY:    if (copyAck) nextState = ST_MAP;
      ST_MAP:     nextState = pLast ? ST_ERASE : ST_SCAN;
      ST_ERASE:   if (eraseAck) nextState = ST_RECLAIM;
      ST_RECLAIM: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      stallQ <= 1'b0;
    end else begin
      state  <= nextState;
      stallQ <= fgMode | (stallQ & (state != ST_RECLAIM));
    end
  end

  always_comb begin
    stb.latch     = (state == ST_SELECT) && victimVld;
    stb.skip      = (state == ST_SCAN) && !curValid && !pLast;
    stb.copyDone  = (state == ST_COPY) && copyAck;
    stb.advance   = (state == ST_MAP);
    stb.eraseDone = (state == ST_ERASE) && eraseAck;
  end

  assign victimReq = (state == ST_SELECT);
  assign copyReq   = (state == ST_COPY);
  assign mapWe     = (state == ST_MAP);
  assign eraseReq  = (state == ST_ERASE);
  assign freePush  = (state == ST_RECLAIM);
  assign hostStall = stallQ;

endmodule

// File: rtl/gc_seq_dp.sv
module gc_seq_dp
  import gc_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGES      = 4,
  parameter int LPA_W      = 6,
  parameter int ERASE_W    = 8,
  parameter int CNT_W      = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int PPA_W     = BLK_W + PG_W,
  localparam int NUM_PPA   = NUM_BLOCKS * PAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  gcStrobe_t          stb,
  input  logic [BLK_W-1:0]   victimIdx,
  input  logic [BLK_W-1:0]   dstIdx,
  input  logic               hostWrEn,
  input  logic [BLK_W-1:0]   hostWrBlk,
  input  logic [PG_W-1:0]    hostWrPage,
  input  logic [LPA_W-1:0]   hostWrLpa,
  input  logic               hostInvEn,
  input  logic [BLK_W-1:0]   hostInvBlk,
  input  logic [PG_W-1:0]    hostInvPage,
  input  logic [BLK_W-1:0]   probeBlk,
  output logic               victimEmpty,
  output logic               curValid,
  output logic               pLast,
  output logic [BLK_W-1:0]   victimBlk,
  output logic [BLK_W-1:0]   destBlk,
  output logic [PG_W-1:0]    srcPage,
  output logic [PG_W-1:0]    dstPage,
  output logic [LPA_W-1:0]   mapLpa,
  output logic [PPA_W-1:0]   mapPpa,
  output logic [CNT_W-1:0]   hostWrCnt,
  output logic [CNT_W-1:0]   gcWrCnt,
  output logic [PAGES-1:0]   probeValid,
  output logic [ERASE_W-1:0] probeErase
);

  logic [NUM_BLOCKS-1:0][PAGES-1:0] validQ;
  logic [LPA_W-1:0]   revMap [NUM_PPA];
  logic [ERASE_W-1:0] wearQ  [NUM_BLOCKS];
  logic [BLK_W-1:0]   victimQ, dstQ;
  logic [PG_W-1:0]    pIdx, dPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      victimQ   <= '0;
      dstQ      <= '0;
      pIdx      <= '0;
      dPtr      <= '0;
      hostWrCnt <= '0;
      gcWrCnt   <= '0;
      for (int i = 0; i < NUM_PPA; i++) revMap[i] <= '0;
    end else begin
      if (stb.latch) begin
        victimQ <= victimIdx;
        dstQ    <= dstIdx;
        pIdx    <= '0;
        dPtr    <= '0;
      end
      if (stb.skip) pIdx <= pIdx + 1'b1;
      if (stb.advance) begin
        pIdx <= pIdx + 1'b1;
        dPtr <= dPtr + 1'b1;
      end
      if (stb.copyDone) begin
        validQ[dstQ][dPtr]  <= 1'b1;
        revMap[{dstQ, dPtr}] <= revMap[{victimQ, pIdx}];
        gcWrCnt             <= gcWrCnt + 1'b1;
      end
      if (stb.eraseDone) validQ[victimQ] <= '0;
      if (hostWrEn) begin
        validQ[hostWrBlk][hostWrPage]  <= 1'b1;
        revMap[{hostWrBlk, hostWrPage}] <= hostWrLpa;
        hostWrCnt                      <= hostWrCnt + 1'b1;
      end
      if (hostInvEn) validQ[hostInvBlk][hostInvPage] <= 1'b0;
    end
  end

  // One wear counter per block, each bumped by its own erase
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_wear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wearQ[b] <= '0;
      else if (stb.eraseDone && (victimQ == BLK_W'(b))) wearQ[b] <= wearQ[b] + 1'b1;
    end
  end

  assign victimEmpty = (validQ[victimIdx] == '0);
  assign curValid    = validQ[victimQ][pIdx];
  assign pLast       = (pIdx == PG_W'(PAGES - 1));
  assign victimBlk   = victimQ;
  assign destBlk     = dstQ;
  assign srcPage     = pIdx;
  assign dstPage     = dPtr;
  assign mapLpa      = revMap[{victimQ, pIdx}];
  assign mapPpa      = {dstQ, dPtr};
  assign probeValid  = validQ[probeBlk];
  assign probeErase  = wearQ[probeBlk];

endmodule

// File: rtl/gc_seq.sv
module gc_seq
  import gc_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGES      = 4,
  parameter int LPA_W      = 6,
  parameter int ERASE_W    = 8,
  parameter int CNT_W      = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int PG_W      = $clog2(PAGES),
  localparam int PPA_W     = BLK_W + PG_W,
  localparam int FREE_W    = $clog2(NUM_BLOCKS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FREE_W-1:0]  freeCount,
  input  logic [FREE_W-1:0]  threshold,
  input  logic               hostIdle,
  input  logic               fgMode,
  output logic               hostStall,
  output logic               victimReq,
  input  logic               victimVld,
  input  logic [BLK_W-1:0]   victimIdx,
  input  logic [BLK_W-1:0]   dstIdx,
  output logic               copyReq,
  input  logic               copyAck,
  output logic [BLK_W-1:0]   copySrcBlk,
  output logic [PG_W-1:0]    copySrcPage,
  output logic [BLK_W-1:0]   copyDstBlk,
  output logic [PG_W-1:0]    copyDstPage,
  output logic               mapWe,
  output logic [LPA_W-1:0]   mapLpa,
  output logic [PPA_W-1:0]   mapPpa,
  output logic               eraseReq,
  input  logic               eraseAck,
  output logic [BLK_W-1:0]   eraseBlk,
  output logic               freePush,
  output logic [BLK_W-1:0]   freeBlk,
  input  logic               hostWrEn,
  input  logic [BLK_W-1:0]   hostWrBlk,
  input  logic [PG_W-1:0]    hostWrPage,
  input  logic [LPA_W-1:0]   hostWrLpa,
  input  logic               hostInvEn,
  input  logic [BLK_W-1:0]   hostInvBlk,
  input  logic [PG_W-1:0]    hostInvPage,
  output logic [CNT_W-1:0]   hostWrCnt,
  output logic [CNT_W-1:0]   gcWrCnt,
  input  logic [BLK_W-1:0]   probeBlk,
  output logic [PAGES-1:0]   probeValid,
  output logic [ERASE_W-1:0] probeErase
);

  gcStrobe_t        stb;
  logic             victimEmpty, curValid, pLast;
  logic [BLK_W-1:0] victimBlk, destBlk;

  gc_seq_ctrl #(.FREE_W(FREE_W)) ctrl_i (
    .clk, .rstN, .freeCount, .threshold, .hostIdle, .fgMode, .victimVld,
    .victimEmpty, .curValid, .pLast, .copyAck, .eraseAck, .stb,
    .victimReq, .copyReq, .mapWe, .eraseReq, .freePush, .hostStall
  );

  gc_seq_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .LPA_W(LPA_W),
    .ERASE_W(ERASE_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk, .rstN, .stb, .victimIdx, .dstIdx,
    .hostWrEn, .hostWrBlk, .hostWrPage, .hostWrLpa,
    .hostInvEn, .hostInvBlk, .hostInvPage, .probeBlk,
    .victimEmpty, .curValid, .pLast, .victimBlk, .destBlk,
    .srcPage(copySrcPage), .dstPage(copyDstPage), .mapLpa, .mapPpa,
    .hostWrCnt, .gcWrCnt, .probeValid, .probeErase
  );

  assign copySrcBlk = victimBlk;
  assign copyDstBlk = destBlk;
  assign eraseBlk   = victimBlk;
  assign freeBlk    = victimBlk;

endmodule

// File: rtl/gc_seq_chk.sv
module gc_seq_chk #(
  parameter int CNT_W = 16,
  parameter int BLK_W = 3,
  parameter int PG_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             fgMode,
  input logic             hostStall,
  input logic             victimReq,
  input logic             copyReq,
  input logic             copyAck,
  input logic [PG_W-1:0]  copySrcPage,
  input logic [PG_W-1:0]  copyDstPage,
  input logic             mapWe,
  input logic             eraseReq,
  input logic             eraseAck,
  input logic [BLK_W-1:0] eraseBlk,
  input logic             freePush,
  input logic [BLK_W-1:0] freeBlk,
  input logic [CNT_W-1:0] gcWrCnt
);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({victimReq, copyReq, mapWe, eraseReq, freePush})); // R12

  AST_COPY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    copyReq && !copyAck |=> copyReq && $stable(copySrcPage) && $stable(copyDstPage)); // R3

  AST_MAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    copyReq && copyAck |=> mapWe); // R4

  AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq && !eraseAck |=> eraseReq && $stable(eraseBlk)); // R5

  AST_PUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq && eraseAck |=> freePush && (freeBlk == $past(eraseBlk))); // R7

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    freePush |=> !freePush); // R7

  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rstN)
    fgMode |=> hostStall); // R9

  AST_STALL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    freePush && !fgMode |=> !hostStall); // R9

  AST_GC_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    copyReq && copyAck |=> gcWrCnt == $past(gcWrCnt) + 1'b1); // R10

endmodule

bind gc_seq gc_seq_chk #(.CNT_W(CNT_W), .BLK_W(BLK_W), .PG_W(PG_W)) chk_i (
  .clk, .rstN, .fgMode, .hostStall, .victimReq, .copyReq, .copyAck,
  .copySrcPage, .copyDstPage, .mapWe, .eraseReq, .eraseAck, .eraseBlk,
  .freePush, .freeBlk, .gcWrCnt
);

// File: tb/gc_seq_tb_top.sv
`timescale 1ns/1ps
module gc_seq_tb_top;

  localparam int NB = 8;
  localparam int NP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] freeCount = 4'd8;
  logic [3:0] threshold = 4'd3;
  logic       hostIdle = 1'b0, fgMode = 1'b0, hostStall;
  logic       victimReq, victimVld = 1'b0;
  logic [2:0] victimIdx = '0, dstIdx = '0;
  logic       copyReq, copyAck = 1'b0;
  logic [2:0] copySrcBlk, copyDstBlk;
  logic [1:0] copySrcPage, copyDstPage;
  logic       mapWe;
  logic [5:0] mapLpa;
  logic [4:0] mapPpa;
  logic       eraseReq, eraseAck = 1'b0;
  logic [2:0] eraseBlk;
  logic       freePush;
  logic [2:0] freeBlk;
  logic       hostWrEn = 1'b0;
  logic [2:0] hostWrBlk = '0;
  logic [1:0] hostWrPage = '0;
  logic [5:0] hostWrLpa = '0;
  logic       hostInvEn = 1'b0;
  logic [2:0] hostInvBlk = '0;
  logic [1:0] hostInvPage = '0;
  logic [15:0] hostWrCnt, gcWrCnt;
  logic [2:0] probeBlk = '0;
  logic [3:0] probeValid;
  logic [7:0] probeErase;

  always #2 clk = ~clk;

  gc_seq dut_i (
    .clk, .rstN, .freeCount, .threshold, .hostIdle, .fgMode, .hostStall,
    .victimReq, .victimVld, .victimIdx, .dstIdx, .copyReq, .copyAck,
    .copySrcBlk, .copySrcPage, .copyDstBlk, .copyDstPage, .mapWe, .mapLpa,
    .mapPpa, .eraseReq, .eraseAck, .eraseBlk, .freePush, .freeBlk,
    .hostWrEn, .hostWrBlk, .hostWrPage, .hostWrLpa, .hostInvEn, .hostInvBlk,
    .hostInvPage, .hostWrCnt, .gcWrCnt, .probeBlk, .probeValid, .probeErase
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench model
  int mValid [NB];
  int mLpa   [NB*NP];
  int mWear  [NB];
  int mHost = 0;
  int mGc   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: all requirements actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic hostWrite(input int b, input int p, input int lpa);
    hostWrEn = 1'b1; hostWrBlk = 3'(b); hostWrPage = 2'(p); hostWrLpa = 6'(lpa);
    @(negedge clk);
    hostWrEn = 1'b0;
    mValid[b] |= (1 << p);
    mLpa[b*NP+p] = lpa;
    mHost++;
  endtask

  task automatic hostInv(input int b, input int p);
    hostInvEn = 1'b1; hostInvBlk = 3'(b); hostInvPage = 2'(p);
    @(negedge clk);
    hostInvEn = 1'b0;
    mValid[b] &= ~(1 << p);
  endtask

  function automatic int kthBit(input int pat, input int k);
    int n = 0;
    for (int p = 0; p < NP; p++) begin
      if (pat[p]) begin
        if (n == k) return p;
        n++;
      end
    end
    return -1;
  endfunction

  task automatic runPass(input int v, input int d, input int cLat, input int eLat,
                         input bit useIdle, input bit stallOn);
    int pat = mValid[v];
    int nExp = $countones(4'(pat));
    int k = 0;
    int maps = 0;
    bit done = 0;
    int guard = 0;
    if (useIdle) hostIdle = 1'b1;
    else begin threshold = 4'd3; freeCount = 4'd2; end
    @(negedge clk);
    chk(victimReq == 1'b1, "R1 pass start", victimReq, 1);
    hostIdle = 1'b0; freeCount = 4'd5;
    victimIdx = 3'(v); dstIdx = 3'(d); victimVld = 1'b1;
    @(negedge clk);
    victimVld = 1'b0;
    if (nExp == 0) chk(eraseReq == 1'b1, "R8 empty victim goes to erase", eraseReq, 1);
    while (!done && guard < 300) begin
      guard++;
      if (copyReq) begin
        int sp = kthBit(pat, k);
        chk(copySrcBlk == 3'(v) && copyDstBlk == 3'(d), "R2 copy blocks",
            {copySrcBlk, copyDstBlk}, {3'(v), 3'(d)});
        chk(copySrcPage == 2'(sp) && copyDstPage == 2'(k), "R3 copy pages",
            {copySrcPage, copyDstPage}, {2'(sp), 2'(k)});
        repeat (cLat) begin
          @(negedge clk);
          chk(copyReq == 1'b1, "R3 copy held until ack", copyReq, 1);
        end
        copyAck = 1'b1;
        @(negedge clk);
        copyAck = 1'b0;
        chk(mapWe == 1'b1, "R4 map strobe", mapWe, 1);
        chk(mapLpa == 6'(mLpa[v*NP+sp]), "R4 map lpa", mapLpa, mLpa[v*NP+sp]);
        chk(mapPpa == 5'(d*NP+k), "R4 map ppa", mapPpa, d*NP+k);
        mLpa[d*NP+k] = mLpa[v*NP+sp];
        mValid[d] |= (1 << k);
        mGc++;
        k++; maps++;
        @(negedge clk);
      end else if (eraseReq) begin
        chk(k == nExp, "R5 erase after all copies", k, nExp);
        chk(eraseBlk == 3'(v), "R5 erase block", eraseBlk, v);
        if (stallOn) chk(hostStall == 1'b1, "R9 stall held during pass", hostStall, 1);
        repeat (eLat) begin
          @(negedge clk);
          chk(eraseReq == 1'b1, "R5 erase held until ack", eraseReq, 1);
        end
        eraseAck = 1'b1;
        @(negedge clk);
        eraseAck = 1'b0;
        chk(freePush == 1'b1 && freeBlk == 3'(v), "R7 free push", {freePush, freeBlk}, {1'b1, 3'(v)});
        mValid[v] = 0;
        mWear[v]++;
        @(negedge clk);
        chk(!freePush && !victimReq, "R7 single push then idle", {freePush, victimReq}, 0);
        chk(hostStall == 1'b0, "R9 stall released after reclaim", hostStall, 0);
        done = 1;
      end else begin
        if (mapWe) chk(0, "R4 stray map strobe", 1, 0);
        @(negedge clk);
      end
    end
    chk(done, "R7 pass completed", done, 1);
    chk(maps == nExp, "R8 map updates match valid pages", maps, nExp);
    probeBlk = 3'(v);
    #0.5;
    chk(probeValid == 4'd0, "R6 victim bitmap cleared", probeValid, 0);
    chk(probeErase == 8'(mWear[v]), "R6 wear counter", probeErase, mWear[v]);
    probeBlk = 3'(d);
    #0.5;
    chk(probeValid == 4'(mValid[d]), "R6 destination bitmap", probeValid, mValid[d]);
    chk(gcWrCnt == 16'(mGc), "R10 copy counter", gcWrCnt, mGc);
    chk(hostWrCnt == 16'(mHost), "R10 host counter", hostWrCnt, mHost);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin mValid[i] = 0; mWear[i] = 0; end
    for (int i = 0; i < NB*NP; i++) mLpa[i] = 0;
    repeat (3) @(negedge clk);
    chk(victimReq == 0 && hostStall == 0 && hostWrCnt == 0 && gcWrCnt == 0,
        "R1 reset state", {victimReq, hostStall}, 0);
    chk(probeValid == 0 && probeErase == 0, "R6 reset tables", probeValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // No trigger: count equal to the limit and host busy
    freeCount = 4'd3; threshold = 4'd3;
    begin
      bit seen = 0;
      repeat (6) begin @(negedge clk); if (victimReq) seen = 1; end
      chk(!seen, "R1 no pass at count equal to limit", seen, 0);
    end
    freeCount = 4'd5;

    for (int pat = 0; pat < 16; pat++) begin
      int v = pat % NB;
      int d = (pat + 3) % NB;
      for (int p = 0; p < NP; p++) begin hostInv(v, p); hostInv(d, p); end
      for (int p = 0; p < NP; p++) hostWrite(v, p, (pat*NP + p) % 64);
      for (int p = 0; p < NP; p++) if (!pat[p]) hostInv(v, p);
      probeBlk = 3'(v);
      #0.5;
      chk(probeValid == 4'(pat), "R11 bitmap after writes and invalidates", probeValid, pat);
      @(negedge clk);
      if (pat == 5) begin
        fgMode = 1'b1;
        @(negedge clk);
        fgMode = 1'b0;
        chk(hostStall == 1'b1, "R9 stall raised", hostStall, 1);
      end
      runPass(v, d, pat % 3, (pat % 4) + 1, pat[0], pat == 5);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule